// File: doc/BRIEF.md
# Twelve-Channel Serial Trim Code Register Bank

This block is the digital core of a twelve-channel, 8-bit trim converter. A host writes it through a three-wire serial port: an active-low select, a serial clock and a serial data line. While select is low, every rising serial clock edge moves one more bit into a 12-bit shift register. When select is released, the upper four bits of that register name a channel and the lower eight bits become that channel's new code. Each channel keeps its own code and drives it on its own 8-bit slice of a wide output bus. The analog ladder that turns a code into a voltage is not part of the block.

The port pins are asynchronous to the system clock. They pass through a two-flop synchronizer and are edge-detected in the system clock domain before use. A shutdown input is synchronized in the same way and drives a flag that marks all twelve outputs as disconnected. An active-low reset sets every channel to midscale.

Top module: `trim_dac_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every channel code reads 128 (midscale) and the disconnect flag reads 0, until the first write.
- R2: Serial clock edges seen while select is high do not change the shift register. A later select pulse with no clock edges reloads the previously shifted word.
- R3: Bits enter most significant first. The first bit received ends up as bit 11. Bits 11..8 are the channel address and bits 7..0 are the code.
- R4: If more than 12 bits are clocked during one select-low period, only the last 12 bits received decide the address and the code.
- R5: A channel register is written only when select rises. That write reaches exactly the one channel whose number equals the address (0..11 give channels 0..11). All other channels keep their codes.
- R6: Address values 12, 13, 14 and 15 change no channel.
- R7: The disconnect flag follows the shutdown input after synchronization. Codes stay stored, and writes still take effect, while shutdown is asserted.
- R8: When a serial clock rising edge and the release of select reach the core in the same system cycle, that clock edge does not shift. The write uses the word as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, rising edge shifts (asynchronous) |
| sdi | input | 1 | Serial data input (asynchronous) |
| shdn | input | 1 | Shutdown request, active high (asynchronous) |
| codes | output | 96 | Channel codes, channel i on bits [8*i+7:8*i] |
| out_off | output | 1 | All outputs flagged disconnected |

## Verification
A serial clock rising edge and the release of select can land in the same system cycle. In that case one function wants to shift and the other wants to commit the word. The bench provokes this by sending a thirteenth bit whose clock rise is driven on the same system-clock edge as the select release. Because both pins use synchronizers of equal depth, the two events reach the core together. The expected result is the 12-bit word from before that edge. If the design had shifted that bit in, the command would change to address 9 with code 0x35 instead of address 4 with code 0x9A, so checking all twelve channels shows which path won.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // Strobes produced by the port front end, one system cycle wide
  typedef struct packed {
    logic shift;
    logic load;
  } tdc_strobe_t;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tdc_front.sv
module tdc_front
  import tdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_s,
  input  logic        sclk_s,
  output tdc_strobe_t strb
);
  logic cs_prev_q, sclk_prev_q;

  always_comb begin
    // a clock rise counts only while select is low in this very cycle
    strb.shift = sclk_s & ~sclk_prev_q & ~cs_n_s;
    strb.load  = cs_n_s & ~cs_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b1;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
    end
  end

  // R8: a release cycle never shifts
  a_r8_load_excludes_shift: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> !strb.shift);
  // R5: a commit strobe lasts one cycle
  a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> !strb.load);
endmodule

// File: rtl/tdc_shifter.sv
module tdc_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R2: without a qualified clock edge the register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
  // R3: newest bit lands at the least significant end
  a_r3_lsb_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(sdi_s)));
endmodule

// File: rtl/tdc_chan_bank.sv
module tdc_chan_bank #(
  parameter int NUM_CH = 12,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CODE_W-1:0]        code,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

  logic [NUM_CH-1:0] wr_en;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CODE_W-1:0] q, d;

    always_comb begin
      wr_en[i] = load_en && (addr == ADDR_W'(i));
      d        = wr_en[i] ? code : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= MIDSCALE;
      else        q <= d;
    end

    assign codes[i*CODE_W +: CODE_W] = q;
  end

  // R5: nothing moves except on a commit
  a_r5_no_write_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(codes));
  // R6: out-of-range addresses leave the bank untouched
  a_r6_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (addr >= ADDR_W'(NUM_CH))) |=> $stable(codes));
  // R5: at most one channel enabled
  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/trim_dac_ctrl.sv
module trim_dac_ctrl
  import tdc_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic                     shdn,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic                     out_off
);
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int WORD_W = ADDR_W + CODE_W;

  // bit order: {shdn, sdi, sclk, cs_n}; select and clock idle high
  logic [3:0]        pins_s;
  tdc_strobe_t       strb;
  logic [WORD_W-1:0] word;

  tdc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({shdn, sdi, sclk, cs_n}),
    .q     (pins_s)
  );

  tdc_front u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_s (pins_s[0]),
    .sclk_s (pins_s[1]),
    .strb   (strb)
  );

  tdc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (strb.shift),
    .sdi_s    (pins_s[2]),
    .word     (word)
  );

  tdc_chan_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (strb.load),
    .addr    (word[WORD_W-1 -: ADDR_W]),
    .code    (word[CODE_W-1:0]),
    .codes   (codes)
  );

  assign out_off = pins_s[3];

  // R7: the flag tracks the shutdown pin once it has settled
  a_r7_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(shdn) && $past($stable(shdn))) |=> (out_off == $past(shdn)));
endmodule

// File: tb/tb_trim_dac_ctrl.sv
module tb_trim_dac_ctrl;
  localparam int NCH = 12;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, shdn;
  logic [NCH*CW-1:0] codes;
  logic out_off;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [CW-1:0] model [NCH];

  always #5 clk = ~clk;

  trim_dac_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn(shdn), .codes(codes), .out_off(out_off)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) chk(int'(codes[c*CW +: CW]), int'(model[c]), req);
  endtask

  task automatic model_write(input logic [11:0] w);
    if (w[11:8] < 4'(NCH)) model[w[11:8]] = w[7:0];
  endtask

  task automatic clock_bits(input logic [31:0] bits, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdi = bits[k];
      sclk = 1'b0; tick(4);
      sclk = 1'b1; tick(4);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0; tick(4);
    clock_bits(bits, n);
    cs_n = 1'b1; tick(10);
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) model[c] = 8'd128;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0; shdn = 1'b0;
    model_reset();
    tick(3);
    check_all("R1 in reset");
    chk(int'(out_off), 0, "R1 flag");
    rst_n = 1'b1; tick(5);
    check_all("R1 after release");

    // R5: several patterns on every channel
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] pats [4];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'(c * 19 + 7);
      for (int p = 0; p < 4; p++) begin
        logic [11:0] w;
        w = {4'(c), pats[p]};
        send(32'(w), 12); model_write(w);
        check_all("R5");
      end
    end

    // R3: walking one through the code field
    for (int b = 0; b < 8; b++) begin
      logic [11:0] w;
      w = {4'd3, 8'(1 << b)};
      send(32'(w), 12); model_write(w);
      check_all("R3");
    end

    // R3/R5: full code sweep on one channel
    for (int v = 0; v < 256; v++) begin
      logic [11:0] w;
      w = {4'd6, 8'(v)};
      send(32'(w), 12); model_write(w);
      check_all("R3 sweep");
    end

    // R6: unused addresses
    for (int a = 12; a < 16; a++) begin
      send(32'({4'(a), 8'hA5}), 12);
      check_all("R6");
    end

    // R4: overlong words keep the last 12 bits
    send({16'h0, 4'b1011, 4'd2, 8'h3C}, 16); model_write({4'd2, 8'h3C});
    check_all("R4 16 bits");
    send({12'h0, 8'hE7, 4'd10, 8'hC1}, 20); model_write({4'd10, 8'hC1});
    check_all("R4 20 bits");

    // R2: clocks with select high are ignored, empty pulse reloads
    send(32'({4'd9, 8'h42}), 12); model_write({4'd9, 8'h42});
    clock_bits(32'({4'd1, 8'hEE}), 12);
    tick(4);
    cs_n = 1'b0; tick(6); cs_n = 1'b1; tick(10);
    check_all("R2");

    // R8: last clock rise coincides with select release
    cs_n = 1'b0; tick(4);
    clock_bits(32'({4'd4, 8'h9A}), 12);
    sdi = 1'b1; sclk = 1'b0; tick(4);
    sclk = 1'b1; cs_n = 1'b1; tick(10);
    model_write({4'd4, 8'h9A});
    check_all("R8");

    // R7: shutdown flag, writes still land
    shdn = 1'b1; tick(5);
    chk(int'(out_off), 1, "R7 flag set");
    check_all("R7 codes kept");
    send(32'({4'd0, 8'h77}), 12); model_write({4'd0, 8'h77});
    check_all("R7 write during shutdown");
    chk(int'(out_off), 1, "R7 flag held");
    shdn = 1'b0; tick(5);
    chk(int'(out_off), 0, "R7 flag clear");

    // R1: reset mid-run returns to midscale
    rst_n = 1'b0; tick(2); model_reset();
    check_all("R1 second reset");
    rst_n = 1'b1; tick(5);
    check_all("R1 second release");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule